// File: doc/BRIEF.md
# Flash Program-Cycle Status Responder

This block stands in for the read side of a 16-bit word-wide flash array while an internal program cycle is running. Word writes carry an address and data. An authorised burst of writes fills a small sector buffer. When the buffer is full, a program timer starts. The buffered words reach the array only when the timer expires. While the timer runs, the block asserts a busy output, and reads return status words instead of plain array contents.

A status word differs from the stored word in four bit positions. Bits 6 and 14 carry a toggle that flips on every read made during the cycle. Bits 7 and 15 carry the inverse of the last word loaded, but only when the read address is the address of that last word. All other bits come from the addressed word as it is stored now.

When protection is enabled, a write that does not arrive with the unlock flag set still starts the timer. Such a write fills no buffer and changes no array word. This gives a dummy busy period in which reads poll exactly as they do in a real cycle. The unlock command decoder is outside the block, and `unlock_ok` reports its result.

Top module: `flash_poll_responder`

## Requirements
- R1: After reset, `busy` is 0, `rd_data` is 0, and every array word reads back as 16'hFFFF.
- R2: When protection is off, or when `unlock_ok` is 1 on the first write of a sector, SECTOR_WORDS accepted writes fill the buffer. `busy` goes high on the cycle after the clock edge that takes the last of those words, and it stays high for exactly PROG_CYCLES cycles.
- R3: A read during `busy` whose address equals the address of the last word loaded returns bits 7 and 15 inverted relative to that loaded word.
- R4: During `busy`, bits 6 and 14 of each read both equal a toggle value. That value is 0 for the first read after a cycle starts, and it inverts after every read made while busy.
- R5: During `busy`, all bits other than 6 and 14 come from the word now stored at the read address. Bits 7 and 15 are included in this rule when the read address is not the last loaded address.
- R6: The buffered words are written into the array at the clock edge where `busy` falls. If two buffered words share an address, the later write wins. Reads made after that edge return the true stored data on all 16 bits.
- R7: When `prot_en` is 1 and `unlock_ok` is 0 on a write that opens a sector, `busy` is held for PROG_CYCLES cycles with status reads as in R3 to R5, and no array word changes.
- R8: A write that arrives while `busy` is high is ignored. It changes no array word and does not extend or restart the busy period.
- R9: `rd_data` takes a new value only at a clock edge where `rd_en` is 1, and it holds its value otherwise. Reads made while a sector is still being filled return plain array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 16 | Write data |
| prot_en | input | 1 | Write protection enabled |
| unlock_ok | input | 1 | The unlock sequence preceded this write |
| rd_en | input | 1 | Read strobe; the result is registered |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 16 | Registered read result, either data or status |
| busy | output | 1 | High while the program timer runs |

## Verification
The assertions assume that `wr_addr` and `rd_addr` are always within the array. They also assume that `unlock_ok` matters only on a write that opens a sector, and that inputs settle between clock edges. The bench drives every input on the falling edge and draws addresses only from the array range. It mixes seeded random reads and writes with random protect and unlock flags, including writes during busy periods and during sector fills. Those stray writes push the design through its ignore paths while the assertions still hold.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    localparam int WORD_W = 16;
    localparam int TGL_LO = 6;
    localparam int TGL_HI = 14;
    localparam int INV_LO = 7;
    localparam int INV_HI = 15;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_FILL = 2'd1,
        LD_WAIT = 2'd2
    } ld_state_t;

    function automatic word_t poll_word(input word_t stored, input logic tgl,
                                        input logic is_last, input word_t last);
        word_t w;
        w = stored;
        w[TGL_LO] = tgl;
        w[TGL_HI] = tgl;
        if (is_last) begin
            w[INV_LO] = ~last[INV_LO];
            w[INV_HI] = ~last[INV_HI];
        end
        return w;
    endfunction

endpackage

// File: rtl/fpr_prog_timer.sv
module fpr_prog_timer #(
    parameter int PROG_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= LAST;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    a_r2_rise_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
    a_r8_no_start_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt <= LAST);

endmodule

// File: rtl/fpr_loader.sv
module fpr_loader
    import fpr_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int SECTOR_WORDS = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  word_t                          wr_data,
    input  logic                           prot_en,
    input  logic                           unlock_ok,
    input  logic                           done,
    input  logic                           busy,
    output logic                           start,
    output logic                           commit,
    output logic [SECTOR_WORDS*ADDR_W-1:0] slot_addr_flat,
    output logic [SECTOR_WORDS*WORD_W-1:0] slot_data_flat,
    output logic [ADDR_W-1:0]              last_addr,
    output word_t                          last_data
);
    localparam int IW = (SECTOR_WORDS > 1) ? $clog2(SECTOR_WORDS) : 1;
    localparam logic [IW-1:0] FILL_END = IW'(SECTOR_WORDS - 1);

    ld_state_t         state;
    logic [IW-1:0]     fill_idx;
    logic              real_q;
    logic [ADDR_W-1:0] slot_addr [SECTOR_WORDS];
    word_t             slot_data [SECTOR_WORDS];
    logic              locked_write;

    assign locked_write = prot_en && !unlock_ok;

    always_comb begin
        start = 1'b0;
        if (wr_en) begin
            if (state == LD_IDLE)
                start = locked_write || (SECTOR_WORDS == 1);
            else if (state == LD_FILL)
                start = (fill_idx == FILL_END);
        end
    end

    assign commit = done && real_q && (state == LD_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= LD_IDLE;
            fill_idx  <= '0;
            real_q    <= 1'b0;
            last_addr <= '0;
            last_data <= '0;
            for (int i = 0; i < SECTOR_WORDS; i++) begin
                slot_addr[i] <= '0;
                slot_data[i] <= '0;
            end
        end else begin
            case (state)
                LD_IDLE: if (wr_en) begin
                    last_addr <= wr_addr;
                    last_data <= wr_data;
                    if (locked_write) begin
                        real_q <= 1'b0;
                        state  <= LD_WAIT;
                    end else begin
                        slot_addr[0] <= wr_addr;
                        slot_data[0] <= wr_data;
                        real_q       <= 1'b1;
                        if (SECTOR_WORDS == 1) begin
                            state <= LD_WAIT;
                        end else begin
                            state    <= LD_FILL;
                            fill_idx <= IW'(1);
                        end
                    end
                end
                LD_FILL: if (wr_en) begin
                    last_addr           <= wr_addr;
                    last_data           <= wr_data;
                    slot_addr[fill_idx] <= wr_addr;
                    slot_data[fill_idx] <= wr_data;
                    if (fill_idx == FILL_END) begin
                        state    <= LD_WAIT;
                        fill_idx <= '0;
                    end else begin
                        fill_idx <= fill_idx + 1'b1;
                    end
                end
                LD_WAIT: if (done) state <= LD_IDLE;
                default: state <= LD_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < SECTOR_WORDS; g++) begin : g_flat
        assign slot_addr_flat[g*ADDR_W +: ADDR_W] = slot_addr[g];
        assign slot_data_flat[g*WORD_W +: WORD_W] = slot_data[g];
    end

    a_r2_wait_tracks_busy: assert property (@(posedge clk) disable iff (rst)
        (state == LD_WAIT) == busy);
    a_r7_locked_open_no_slot: assert property (@(posedge clk) disable iff (rst)
        (state == LD_IDLE && wr_en && locked_write) |=> !real_q);

endmodule

// File: rtl/fpr_array.sv
module fpr_array
    import fpr_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int SECTOR_WORDS = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           commit,
    input  logic [SECTOR_WORDS*ADDR_W-1:0] slot_addr_flat,
    input  logic [SECTOR_WORDS*WORD_W-1:0] slot_data_flat,
    input  logic [ADDR_W-1:0]              rd_addr,
    output word_t                          rd_word
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int TOP   = SECTOR_WORDS - 1;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit) begin
            for (int s = 0; s < SECTOR_WORDS; s++)
                mem[slot_addr_flat[s*ADDR_W +: ADDR_W]] <= slot_data_flat[s*WORD_W +: WORD_W];
        end
    end

    assign rd_word = mem[rd_addr];

    a_r6_last_slot_lands: assert property (@(posedge clk) disable iff (rst)
        commit |=> mem[$past(slot_addr_flat[TOP*ADDR_W +: ADDR_W])]
                   == $past(slot_data_flat[TOP*WORD_W +: WORD_W]));

endmodule

// File: rtl/fpr_status.sv
module fpr_status
    import fpr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              busy,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  word_t             stored,
    input  logic [ADDR_W-1:0] last_addr,
    input  word_t             last_data,
    output word_t             rd_data
);
    logic tgl;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            tgl     <= 1'b0;
        end else begin
            if (start) tgl <= 1'b0;
            if (rd_en) begin
                if (busy) begin
                    rd_data <= poll_word(stored, tgl, rd_addr == last_addr, last_data);
                    tgl     <= ~tgl;
                end else begin
                    rd_data <= stored;
                end
            end
        end
    end

    a_r4_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) |=> tgl != $past(tgl));
    a_r3_inverse_on_last: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy && rd_addr == last_addr) |=>
            (rd_data[INV_LO] != $past(last_data[INV_LO])) &&
            (rd_data[INV_HI] != $past(last_data[INV_HI])));
    a_r9_hold_without_read: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/flash_poll_responder.sv
module flash_poll_responder
    import fpr_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int SECTOR_WORDS = 4,
    parameter int PROG_CYCLES  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              prot_en,
    input  logic              unlock_ok,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    output logic              busy
);
    logic                           start, done, commit;
    logic [SECTOR_WORDS*ADDR_W-1:0] slot_addr_flat;
    logic [SECTOR_WORDS*WORD_W-1:0] slot_data_flat;
    logic [ADDR_W-1:0]              last_addr;
    word_t                          last_data;
    word_t                          stored;

    fpr_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done)
    );

    fpr_loader #(.ADDR_W(ADDR_W), .SECTOR_WORDS(SECTOR_WORDS)) u_loader (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prot_en(prot_en), .unlock_ok(unlock_ok), .done(done), .busy(busy),
        .start(start), .commit(commit), .slot_addr_flat(slot_addr_flat),
        .slot_data_flat(slot_data_flat), .last_addr(last_addr), .last_data(last_data)
    );

    fpr_array #(.ADDR_W(ADDR_W), .SECTOR_WORDS(SECTOR_WORDS)) u_array (
        .clk(clk), .rst(rst), .commit(commit), .slot_addr_flat(slot_addr_flat),
        .slot_data_flat(slot_data_flat), .rd_addr(rd_addr), .rd_word(stored)
    );

    fpr_status #(.ADDR_W(ADDR_W)) u_status (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .rd_en(rd_en),
        .rd_addr(rd_addr), .stored(stored), .last_addr(last_addr),
        .last_data(last_data), .rd_data(rd_data)
    );

endmodule

// File: tb/tb_flash_poll_responder.sv
`timescale 1ns/1ps
module tb_flash_poll_responder;
    localparam int AW = 4;
    localparam int SW = 4;
    localparam int PC = 20;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, prot_en = 1'b0, unlock_ok = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic busy;

    always #10 clk = ~clk;

    flash_poll_responder #(.ADDR_W(AW), .SECTOR_WORDS(SW), .PROG_CYCLES(PC)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prot_en(prot_en), .unlock_ok(unlock_ok), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );

    int tests = 0, fails = 0;
    logic [15:0] m_mem [DEPTH];
    logic [AW-1:0] s_addr [SW];
    logic [15:0] s_data [SW];
    logic [AW-1:0] m_last_a = '0;
    logic [15:0] m_last_d = '0;
    bit m_busy = 0, m_real = 0, m_tgl = 0;
    int m_cnt = 0, m_fill = 0, busy_run = 0;
    logic [15:0] exp_rd = '0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] poll_exp(input logic [AW-1:0] a);
        logic [15:0] v;
        v = m_mem[a];
        v[6] = m_tgl;
        v[14] = m_tgl;
        if (a == m_last_a) begin
            v[7] = ~m_last_d[7];
            v[15] = ~m_last_d[15];
        end
        return v;
    endfunction

    task automatic model_start(input bit is_real);
        m_busy = 1; m_cnt = PC; m_tgl = 0; m_real = is_real;
    endtask

    task automatic cyc(input bit rd, input logic [AW-1:0] ra, input bit wr,
                       input logic [AW-1:0] wa, input logic [15:0] wd,
                       input bit unl, input bit prt, input string rtag);
        bit busy_pre;
        string tag;
        rd_en = rd; rd_addr = ra; wr_en = wr; wr_addr = wa; wr_data = wd;
        unlock_ok = unl; prot_en = prt;
        busy_pre = m_busy;
        tag = busy_pre ? "R3 R4 R5" : rtag;
        if (rd) begin
            if (busy_pre) begin
                exp_rd = poll_exp(ra);
                m_tgl = ~m_tgl;
            end else begin
                exp_rd = m_mem[ra];
            end
        end
        if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
                if (m_real) for (int s = 0; s < SW; s++) m_mem[s_addr[s]] = s_data[s];
                m_busy = 0;
            end
        end else if (wr) begin
            m_last_a = wa; m_last_d = wd;
            if (m_fill == 0) begin
                if (prt && !unl) model_start(0);
                else begin
                    s_addr[0] = wa; s_data[0] = wd;
                    if (SW == 1) model_start(1); else m_fill = 1;
                end
            end else begin
                s_addr[m_fill] = wa; s_data[m_fill] = wd;
                if (m_fill == SW - 1) begin m_fill = 0; model_start(1); end
                else m_fill++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check("R2", {15'd0, busy}, {15'd0, m_busy});
        if (busy) busy_run++;
        check(rd ? tag : "R9", rd_data, exp_rd);
        rd_en = 0; wr_en = 0;
    endtask

    task automatic idle_until_free(input string tag);
        int guard = 0;
        while (m_busy && guard < 1000) begin
            cyc(0, '0, 0, '0, '0, 0, 0, tag);
            guard++;
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seed;
        logic [15:0] old3;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 16'hFFFF;
        for (int s = 0; s < SW; s++) begin s_addr[s] = '0; s_data[s] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1", {15'd0, busy}, 16'd0);
        check("R1", rd_data, 16'd0);
        for (int i = 0; i < DEPTH; i++) cyc(1, AW'(i), 0, '0, '0, 0, 0, "R1");

        // R2/R3/R4/R5/R8: unprotected sector, polling, stray write while busy
        cyc(1, 4'd6, 1, 4'd3, 16'h1111, 0, 0, "R9");
        cyc(0, '0, 1, 4'd4, 16'h2222, 0, 0, "R9");
        cyc(1, 4'd3, 1, 4'd5, 16'h3333, 0, 0, "R9");
        busy_run = 0;
        cyc(0, '0, 1, 4'd6, 16'h5A3C, 0, 0, "R2");
        for (int k = 0; k < 4; k++) cyc(1, 4'd6, 0, '0, '0, 0, 0, "R3");
        cyc(1, 4'd2, 0, '0, '0, 0, 0, "R5");
        cyc(0, '0, 1, 4'd9, 16'h0000, 0, 0, "R8");
        cyc(0, '0, 1, 4'd9, 16'h0000, 1, 1, "R8");
        idle_until_free("R8");
        check("R8", 16'(busy_run), 16'(PC));
        cyc(1, 4'd6, 0, '0, '0, 0, 0, "R6");
        check("R6", rd_data, 16'h5A3C);
        cyc(1, 4'd9, 0, '0, '0, 0, 0, "R8");
        check("R8", rd_data, 16'hFFFF);

        // R7: locked write gives dummy busy period and changes nothing
        old3 = m_mem[3];
        busy_run = 0;
        cyc(0, '0, 1, 4'd3, 16'h0000, 0, 1, "R7");
        cyc(1, 4'd3, 0, '0, '0, 0, 0, "R7");
        cyc(1, 4'd3, 0, '0, '0, 0, 0, "R7");
        idle_until_free("R7");
        check("R7", 16'(busy_run), 16'(PC));
        cyc(1, 4'd3, 0, '0, '0, 0, 0, "R7");
        check("R7", rd_data, old3);

        // R6: protected with unlock, duplicate address, later write wins
        cyc(0, '0, 1, 4'd7, 16'hAAAA, 1, 1, "R6");
        cyc(0, '0, 1, 4'd7, 16'hBBBB, 0, 1, "R6");
        cyc(0, '0, 1, 4'd8, 16'h8080, 0, 1, "R6");
        cyc(1, 4'd7, 1, 4'd1, 16'h0F0F, 0, 1, "R9");
        idle_until_free("R6");
        cyc(1, 4'd7, 0, '0, '0, 0, 0, "R6");
        check("R6", rd_data, 16'hBBBB);

        seed = 1234;
        void'($urandom(seed));
        for (int n = 0; n < 1500; n++) begin
            bit rd, wr, pr, un;
            rd = ($urandom % 2) == 0;
            wr = ($urandom % 10) < 3;
            pr = ($urandom % 2) == 0;
            un = ($urandom % 3) != 0;
            cyc(rd, AW'($urandom), wr, AW'($urandom), 16'($urandom), un, pr, "R6");
        end
        idle_until_free("R6");
        for (int i = 0; i < DEPTH; i++) cyc(1, AW'(i), 0, '0, '0, 0, 0, "R6");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule